// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block decides, every cycle, how a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) keeps its register dependences correct. It looks at the register numbers used by the instructions in decode and execute, and at the destination, write-enable and load flags held in the pipeline registers behind them. From these it produces the operand bypass selects for both ALU inputs, hold enables for the program counter and the fetch/decode register, a bubble request for the decode/execute register, and squash signals that fire when a branch resolved in the memory stage is taken.

All register writes happen in write-back, and results that need no memory access pass through an idle memory stage, so only read-after-write dependences need handling. The register file writes in the first half of a cycle and reads in the second, so a decode source that matches the write-back destination needs no action. Fetch continues past a branch on the sequential path, and the three younger instructions are squashed when the branch turns out taken. Every output is a combinational function of the current inputs and acts in the same cycle.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: An ALU operand whose execute-stage source register is nonzero and equals `mem_rd` while `mem_we` is 1 gets select code 2'b10 (take the execute/memory result).
- R2: An ALU operand whose nonzero source equals `wb_rd` with `wb_we` at 1, and that does not meet the condition of R1, gets select code 2'b01 (take the memory/write-back result).
- R3: When the conditions of R1 and R2 both hold for one operand, the select is 2'b10.
- R4: A source register of 0 always gets select 2'b00 (register file) and never causes a stall; any operand with no match also gets 2'b00.
- R5: When `ex_is_load` and `ex_we` are 1, `ex_rd` is nonzero and equals `id_rs1` or `id_rs2`, and no taken branch is flagged, `pc_hold`, `ifid_hold` and `idex_bubble` are all 1 in that same cycle.
- R6: A match between `ex_rd` and a decode source when the execute instruction is not a load causes no hold and no bubble.
- R7: A decode source that equals `wb_rd` or `mem_rd` causes no hold and no bubble.
- R8: When `mem_br_valid` and `mem_br_taken` are both 1, `flush_ifid`, `flush_idex` and `flush_exmem` are all 1; otherwise all three are 0.
- R9: When the conditions of R5 and R8 hold in the same cycle, the three squash signals are 1 and `pc_hold`, `ifid_hold` and `idex_bubble` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_rs1 | input | 5 | First source register of the instruction in decode |
| id_rs2 | input | 5 | Second source register of the instruction in decode |
| ex_rs1 | input | 5 | First source register of the instruction in execute |
| ex_rs2 | input | 5 | Second source register of the instruction in execute |
| ex_rd | input | 5 | Destination in the decode/execute register |
| ex_we | input | 1 | Register write enable in the decode/execute register |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | 5 | Destination in the execute/memory register |
| mem_we | input | 1 | Register write enable in the execute/memory register |
| wb_rd | input | 5 | Destination in the memory/write-back register |
| wb_we | input | 1 | Register write enable in the memory/write-back register |
| mem_br_valid | input | 1 | A branch outcome is present in the memory stage |
| mem_br_taken | input | 1 | The branch in the memory stage is taken |
| fwd_a_sel | output | 2 | Bypass select for ALU operand A |
| fwd_b_sel | output | 2 | Bypass select for ALU operand B |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |
| flush_ifid | output | 1 | Squash the fetch/decode register |
| flush_idex | output | 1 | Squash the decode/execute register |
| flush_exmem | output | 1 | Squash the execute/memory register |

## Verification
The assertions check on every evaluation that register 0 is never bypassed, that a bypass select always names a stage whose destination really matches and is enabled, that a bubble is requested only behind a load, and that a hold never coincides with a squash. Priority of the newer stage over the older one, the absence of a stall for write-back and non-load matches, and the branch-over-stall ordering are shown only by the bench, which drives directed dependent and independent instruction mixes plus random field patterns over a narrow register range and compares every output with its own model.

// File: rtl/phc_pkg.sv
package phc_pkg;
    localparam int FWD_W = 2;

    typedef enum logic [FWD_W-1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic pc_hold;
        logic ifid_hold;
        logic idex_bubble;
        logic flush_ifid;
        logic flush_idex;
        logic flush_exmem;
    } flow_ctl_t;
endpackage

// File: rtl/phc_fwd_sel.sv
module phc_fwd_sel
    import phc_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    output fwd_sel_e      sel
);
    logic src_live;
    logic hit_mem;
    logic hit_wb;

    always_comb begin
        src_live = (src != '0);
        hit_mem  = src_live && mem_we && (mem_rd == src);
        hit_wb   = src_live && wb_we && (wb_rd == src);
        if (hit_mem) begin
            sel = FWD_MEM;
        end else if (hit_wb) begin
            sel = FWD_WB;
        end else begin
            sel = FWD_RF;
        end
    end

    always_comb begin
        assert_zero_not_fwd_R4: assert ((src != '0) || (sel == FWD_RF));
        assert_mem_sel_match_R1: assert ((sel != FWD_MEM) || (mem_we && (mem_rd == src)));
        assert_wb_sel_match_R2: assert ((sel != FWD_WB) || (wb_we && (wb_rd == src)));
    end
endmodule

// File: rtl/phc_loaduse.sv
module phc_loaduse #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_is_load,
    output logic          need_stall
);
    logic dst_live;

    always_comb begin
        dst_live   = ex_is_load && ex_we && (ex_rd != '0);
        need_stall = dst_live && ((ex_rd == id_rs1) || (ex_rd == id_rs2));
    end

    always_comb begin
        assert_stall_needs_load_R6: assert (!need_stall || ex_is_load);
        assert_stall_not_r0_R4: assert (!need_stall || (ex_rd != '0));
    end
endmodule

// File: rtl/phc_flow_ctl.sv
module phc_flow_ctl
    import phc_pkg::*;
(
    input  logic      need_stall,
    input  logic      br_valid,
    input  logic      br_taken,
    output flow_ctl_t ctl_d
);
    logic redirect;

    always_comb begin
        redirect          = br_valid && br_taken;
        ctl_d             = '0;
        ctl_d.flush_ifid  = redirect;
        ctl_d.flush_idex  = redirect;
        ctl_d.flush_exmem = redirect;
        if (!redirect && need_stall) begin
            ctl_d.pc_hold     = 1'b1;
            ctl_d.ifid_hold   = 1'b1;
            ctl_d.idex_bubble = 1'b1;
        end
    end

    always_comb begin
        assert_hold_vs_flush_R9: assert (!(ctl_d.pc_hold && ctl_d.flush_ifid));
        assert_flush_on_taken_R8: assert (ctl_d.flush_exmem == (br_valid && br_taken));
    end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
    import phc_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0]    id_rs1,
    input  logic [AW-1:0]    id_rs2,
    input  logic [AW-1:0]    ex_rs1,
    input  logic [AW-1:0]    ex_rs2,
    input  logic [AW-1:0]    ex_rd,
    input  logic             ex_we,
    input  logic             ex_is_load,
    input  logic [AW-1:0]    mem_rd,
    input  logic             mem_we,
    input  logic [AW-1:0]    wb_rd,
    input  logic             wb_we,
    input  logic             mem_br_valid,
    input  logic             mem_br_taken,
    output logic [FWD_W-1:0] fwd_a_sel,
    output logic [FWD_W-1:0] fwd_b_sel,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble,
    output logic             flush_ifid,
    output logic             flush_idex,
    output logic             flush_exmem
);
    localparam int NSRC = 2;

    logic [AW-1:0] ex_src [NSRC];
    fwd_sel_e      sel    [NSRC];
    logic          need_stall;
    flow_ctl_t     ctl_d;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    for (genvar g = 0; g < NSRC; g++) begin : g_op
        phc_fwd_sel #(.AW(AW)) i_fwd (
            .src    (ex_src[g]),
            .mem_rd (mem_rd),
            .mem_we (mem_we),
            .wb_rd  (wb_rd),
            .wb_we  (wb_we),
            .sel    (sel[g])
        );
    end

    phc_loaduse #(.AW(AW)) i_loaduse (
        .id_rs1     (id_rs1),
        .id_rs2     (id_rs2),
        .ex_rd      (ex_rd),
        .ex_we      (ex_we),
        .ex_is_load (ex_is_load),
        .need_stall (need_stall)
    );

    phc_flow_ctl i_flow (
        .need_stall (need_stall),
        .br_valid   (mem_br_valid),
        .br_taken   (mem_br_taken),
        .ctl_d      (ctl_d)
    );

    assign fwd_a_sel   = sel[0];
    assign fwd_b_sel   = sel[1];
    assign pc_hold     = ctl_d.pc_hold;
    assign ifid_hold   = ctl_d.ifid_hold;
    assign idex_bubble = ctl_d.idex_bubble;
    assign flush_ifid  = ctl_d.flush_ifid;
    assign flush_idex  = ctl_d.flush_idex;
    assign flush_exmem = ctl_d.flush_exmem;

    always_comb begin
        assert_bubble_with_hold_R5: assert (idex_bubble == pc_hold);
        assert_bubble_only_load_R6: assert (!idex_bubble || (ex_is_load && ex_we));
    end
endmodule

// File: tb/test_pipe_hazard_ctl.sv
module test_pipe_hazard_ctl;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic ex_we, ex_is_load, mem_we, wb_we, mem_br_valid, mem_br_taken;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic pc_hold, ifid_hold, idex_bubble, flush_ifid, flush_idex, flush_exmem;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pipe_hazard_ctl i_pipe_hazard_ctl (.*);

    function automatic logic [1:0] model_fwd(int src);
        if (src != 0 && mem_we && int'(mem_rd) == src) return 2'b10;
        if (src != 0 && wb_we && int'(wb_rd) == src) return 2'b01;
        return 2'b00;
    endfunction

    function automatic bit model_stall();
        if (mem_br_valid && mem_br_taken) return 1'b0;
        if (!(ex_is_load && ex_we) || ex_rd == 0) return 1'b0;
        return (ex_rd == id_rs1) || (ex_rd == id_rs2);
    endfunction

    task automatic cmp(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
        mem_rd = 0; wb_rd = 0; ex_we = 0; ex_is_load = 0;
        mem_we = 0; wb_we = 0; mem_br_valid = 0; mem_br_taken = 0;
    endtask

    task automatic step(string tag);
        bit st, fl;
        @(negedge clk);
        #2;
        st = model_stall();
        fl = mem_br_valid && mem_br_taken;
        cmp({tag, " fwd_a"}, fwd_a_sel, model_fwd(ex_rs1));
        cmp({tag, " fwd_b"}, fwd_b_sel, model_fwd(ex_rs2));
        cmp({tag, " pc_hold"}, pc_hold, st);
        cmp({tag, " ifid_hold"}, ifid_hold, st);
        cmp({tag, " idex_bubble"}, idex_bubble, st);
        cmp({tag, " flush_ifid"}, flush_ifid, fl);
        cmp({tag, " flush_idex"}, flush_idex, fl);
        cmp({tag, " flush_exmem"}, flush_exmem, fl);
        @(posedge clk);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        step("reset idle R4");
        @(negedge clk); #2;
        cmp("R4 idle sel a", fwd_a_sel, 0);
        cmp("R8 idle flush", flush_exmem, 0);

        idle(); ex_rs1 = 3; mem_rd = 3; mem_we = 1;
        step("R1 mem fwd a");
        @(negedge clk); #2; cmp("R1 sel a code 10", fwd_a_sel, 2);

        idle(); ex_rs2 = 7; wb_rd = 7; wb_we = 1;
        step("R2 wb fwd b");
        @(negedge clk); #2; cmp("R2 sel b code 01", fwd_b_sel, 1);

        idle(); ex_rs1 = 9; ex_rs2 = 9; mem_rd = 9; mem_we = 1; wb_rd = 9; wb_we = 1;
        step("R3 both match");
        @(negedge clk); #2; cmp("R3 newer wins", fwd_a_sel, 2);

        idle(); ex_rs1 = 4; mem_rd = 4; mem_we = 0; wb_rd = 4; wb_we = 1;
        step("R2 mem disabled");

        idle(); mem_rd = 0; mem_we = 1; wb_rd = 0; wb_we = 1;
        ex_rd = 0; ex_we = 1; ex_is_load = 1;
        step("R4 reg zero");
        @(negedge clk); #2;
        cmp("R4 no fwd of r0", fwd_a_sel, 0);
        cmp("R4 no stall on r0", pc_hold, 0);

        idle(); ex_rd = 5; ex_we = 1; ex_is_load = 1; id_rs2 = 5;
        step("R5 load use rs2");
        @(negedge clk); #2;
        cmp("R5 pc_hold", pc_hold, 1);
        cmp("R5 bubble", idex_bubble, 1);

        idle(); ex_rd = 6; ex_we = 1; ex_is_load = 1; id_rs1 = 6;
        step("R5 load use rs1");

        idle(); ex_rd = 6; ex_we = 1; ex_is_load = 0; id_rs1 = 6;
        step("R6 alu no stall");
        @(negedge clk); #2; cmp("R6 no hold alu", ifid_hold, 0);

        idle(); wb_rd = 8; wb_we = 1; mem_rd = 10; mem_we = 1; id_rs1 = 8; id_rs2 = 10;
        step("R7 wb mem no stall");
        @(negedge clk); #2; cmp("R7 no hold wb", pc_hold, 0);

        idle(); mem_br_valid = 1; mem_br_taken = 1;
        step("R8 taken");
        @(negedge clk); #2; cmp("R8 flush_idex", flush_idex, 1);

        idle(); mem_br_valid = 1; mem_br_taken = 0;
        step("R8 not taken");
        idle(); mem_br_valid = 0; mem_br_taken = 1;
        step("R8 invalid");
        @(negedge clk); #2; cmp("R8 no flush invalid", flush_ifid, 0);

        idle(); ex_rd = 2; ex_we = 1; ex_is_load = 1; id_rs1 = 2;
        mem_br_valid = 1; mem_br_taken = 1;
        step("R9 flush over stall");
        @(negedge clk); #2;
        cmp("R9 no hold", pc_hold, 0);
        cmp("R9 flush", flush_ifid, 1);

        for (int i = 0; i < 3000; i++) begin
            id_rs1 = 5'($urandom_range(0, 3)); id_rs2 = 5'($urandom_range(0, 3));
            ex_rs1 = 5'($urandom_range(0, 3)); ex_rs2 = 5'($urandom_range(0, 3));
            ex_rd  = 5'($urandom_range(0, 3)); mem_rd = 5'($urandom_range(0, 3));
            wb_rd  = 5'($urandom_range(0, 3));
            ex_we = 1'($urandom); ex_is_load = 1'($urandom); mem_we = 1'($urandom);
            wb_we = 1'($urandom); mem_br_valid = 1'($urandom);
            mem_br_taken = 1'($urandom);
            step("random R1 R3 R5 R9");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule